// File: doc/BRIEF.md
# Four-Digit Seven-Segment Number/Message Selector

This block drives a four-digit seven-segment display whose digits share one segment bus and are each enabled by their own select line. A mode input picks what the display shows. With the mode input low, a 4-bit binary value is decoded to a single hex character on the leftmost digit. With the mode input high, the word "FAIL" is shown by multiplexing: a clocked scanner lights one digit at a time and puts that digit's letter on the shared bus.

The scanner holds each digit for a fixed number of clock cycles, set by a parameter. This keeps the per-digit refresh in the low-kilohertz range rather than at the clock rate. The scanner runs in both modes. The choice between the scanner and the number decoder is purely combinational, so a change of the mode input reaches the pins in the same cycle.

Top module: `seg_msg_mux`

## Requirements
- R1: While reset (rst, synchronous, active high) is applied, the scanner is at the leftmost position. With the mode input high, the outputs are then dig_n=4'b0111 and seg_n equal to the letter F.
- R2: With the mode input low, seg_n shows the active-low hex glyph of value. seg_n bit 0 is segment a and bit 6 is segment g. Hex 0 is 7'b1000000.
- R3: With the mode input high, the scanner visits the leftmost, mid-left, mid-right and rightmost digits in that order (dig_n 0111, 1011, 1101, 1110). It shows F=7'b0001110, A=7'b0001000, I=7'b1111001 and L=7'b1000111 on them respectively.
- R4: The scanner holds each position for exactly DWELL rising clock edges and changes only on a rising edge.
- R5: After the rightmost position the scanner wraps to the leftmost.
- R6: The mode input selects between the scanner and the decoder combinationally, with no clock edge needed.
- R7: With the mode input low, dig_n is 4'b0111 for every value.
- R8: The scanner keeps stepping while the mode input is low. On a return to high, the display shows the position reached by counting all edges since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_mode | input | 1 | High: scan message; low: show value |
| value | input | 4 | Binary value for the hex digit |
| seg_n | output | 7 | Active-low segments, bit 0 = a ... bit 6 = g |
| dig_n | output | 4 | Active-low digit selects, bit 3 = leftmost |

## Verification
The bench builds the block with DWELL=4. With that setting, a full scan cycle takes sixteen edges, so several wraps, and the exact edge on which each position changes, fit into a few dozen cycles. All sixteen input values are swept in number mode. The bench checks the mode switches between clock edges, and a reset applied in the middle of a scan.

// File: rtl/seg_msg_mux.sv
module seg_msg_mux #(
  parameter int DWELL = 100_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fail_mode,
  input  logic [3:0] value,
  output logic [6:0] seg_n,
  output logic [3:0] dig_n
);
  localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       pos;
  logic [6:0]       msg_seg, hex_seg;
  logic [3:0]       msg_dig;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pos <= 2'd0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      pos <= pos + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign msg_dig = ~(4'b1000 >> pos);

  always_comb begin
    case (pos)
      2'd0:    msg_seg = 7'b0001110;
      2'd1:    msg_seg = 7'b0001000;
      2'd2:    msg_seg = 7'b1111001;
      default: msg_seg = 7'b1000111;
    endcase
  end

  always_comb begin
    case (value)
      4'h0: hex_seg = 7'b1000000;
      4'h1: hex_seg = 7'b1111001;
      4'h2: hex_seg = 7'b0100100;
      4'h3: hex_seg = 7'b0110000;
      4'h4: hex_seg = 7'b0011001;
      4'h5: hex_seg = 7'b0010010;
      4'h6: hex_seg = 7'b0000010;
      4'h7: hex_seg = 7'b1111000;
      4'h8: hex_seg = 7'b0000000;
      4'h9: hex_seg = 7'b0010000;
      4'hA: hex_seg = 7'b0001000;
      4'hB: hex_seg = 7'b0000011;
      4'hC: hex_seg = 7'b1000110;
      4'hD: hex_seg = 7'b0100001;
      4'hE: hex_seg = 7'b0000110;
      default: hex_seg = 7'b0001110;
    endcase
  end

  assign seg_n = fail_mode ? msg_seg : hex_seg;
  assign dig_n = fail_mode ? msg_dig : 4'b0111;
endmodule

// File: rtl/seg_msg_mux_chk.sv
module seg_msg_mux_chk #(
  parameter int DWELL = 4,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             fail_mode,
  input logic [6:0]       seg_n,
  input logic [3:0]       dig_n,
  input logic [1:0]       pos,
  input logic [CNT_W-1:0] cnt
);
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(~dig_n) == 1);
  p_normal_left_r7: assert property (@(posedge clk) disable iff (rst)
    !fail_mode |-> dig_n == 4'b0111);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_W'(DWELL - 1)) |=> $stable(pos));
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(DWELL - 1)) |=> pos == $past(pos) + 2'd1);
  p_first_letter_r3: assert property (@(posedge clk) disable iff (rst)
    (fail_mode && pos == 2'd0) |-> (seg_n == 7'b0001110 && dig_n == 4'b0111));
endmodule

bind seg_msg_mux seg_msg_mux_chk #(.DWELL(DWELL), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fail_mode(fail_mode), .seg_n(seg_n),
  .dig_n(dig_n), .pos(pos), .cnt(cnt)
);

// File: tb/test_seg_msg_mux.sv
`timescale 1ns/1ps
module test_seg_msg_mux;
  localparam int DW = 4;
  logic clk = 1'b0, rst = 1'b1, fail_mode = 1'b1;
  logic [3:0] value = 4'h0;
  logic [6:0] seg_n;
  logic [3:0] dig_n;
  int checks = 0, failures = 0, k = 0;
  bit done = 0;

  seg_msg_mux #(.DWELL(DW)) i_seg_msg_mux (
    .clk(clk), .rst(rst), .fail_mode(fail_mode), .value(value),
    .seg_n(seg_n), .dig_n(dig_n));

  always #5 clk = ~clk;
  always @(posedge clk) k <= rst ? 0 : k + 1;

  function automatic logic [6:0] lit_hex(input logic [3:0] v);
    case (v)
      4'h0: return 7'b0111111; 4'h1: return 7'b0000110;
      4'h2: return 7'b1011011; 4'h3: return 7'b1001111;
      4'h4: return 7'b1100110; 4'h5: return 7'b1101101;
      4'h6: return 7'b1111101; 4'h7: return 7'b0000111;
      4'h8: return 7'b1111111; 4'h9: return 7'b1101111;
      4'hA: return 7'b1110111; 4'hB: return 7'b1111100;
      4'hC: return 7'b0111001; 4'hD: return 7'b1011110;
      4'hE: return 7'b1111001; default: return 7'b1110001;
    endcase
  endfunction

  function automatic logic [6:0] lit_msg(input int p);
    case (p)
      0: return 7'b1110001; 1: return 7'b1110111;
      2: return 7'b0000110; default: return 7'b0111000;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] es, input logic [3:0] ed);
    checks++;
    if (seg_n !== es || dig_n !== ed) begin
      failures++;
      $display("FAIL %s seg=%b dig=%b expected seg=%b dig=%b", req, seg_n, dig_n, es, ed);
    end
  endtask

  task automatic check_scan(input string req);
    int p = (k / DW) % 4;
    check(req, ~lit_msg(p), ~(4'b1000 >> p));
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 7'b0001110, 4'b0111);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check_scan((k >= 16) ? "R5 wrap" : "R3/R4 scan");
    end
    @(negedge clk);
    fail_mode = 1'b0;
    #1 check("R6 switch to number", ~lit_hex(value), 4'b0111);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      value = 4'(v);
      #1 check("R2/R7 hex digit", ~lit_hex(4'(v)), 4'b0111);
    end
    repeat (3) @(negedge clk);
    fail_mode = 1'b1;
    #1 check_scan("R6/R8 return to message");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check_scan("R8 continued scan");
    end
    while (((k / DW) % 4) != 2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-scan", 7'b0001110, 4'b0111);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_scan("R4 scan after reset");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule